// File: doc/BRIEF.md
# Page Write Sequencer with In-Page Wraparound

This block collects the data bytes of one serial write command into a 64-byte page buffer and then programs them into an external byte array during a self-timed busy interval. A sequence is opened by a start pulse carrying the first byte address. The upper address bits select the page and stay fixed for the whole sequence. Each byte that arrives lands at the current in-page offset. The offset then steps by one in its low six bits only, so a long burst wraps back to the start of the same page and overwrites the bytes captured earlier.

The block shows its current address on `cur_addr_o`. A neighbouring protection decoder answers with `writable_i` in the same cycle, and a byte aimed at a non-writable address is dropped. The commit pulse marks the rising edge of the chip select that ends the command. On commit, any captured bytes are programmed one slot per cycle, and `busy_o` stays high for a parameterised number of clock cycles. While busy, new commands are ignored. When the cycle ends, a one-cycle pulse tells the status logic to clear its write-enable latch.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, `busy_o`, `arr_we_o` and `wel_clr_o` are 0 and `cur_addr_o` is 0.
- R2: Every array write of one busy interval uses address bits [ADDR_W-1:6] equal to those of the start address.
- R3: Each accepted byte advances the in-page offset (`cur_addr_o[5:0]`) by one modulo 64, so offset 63 is followed by offset 0. A later byte at an offset replaces the earlier one.
- R4: During the busy interval, each in-page offset that captured a writable byte is written exactly once, with its last captured data. Offsets that captured nothing are not written.
- R5: A byte whose address has `writable_i` low is not captured, but the offset still advances past it.
- R6: A commit when no byte was captured starts no busy interval and produces no array write.
- R7: A commit with at least one captured byte raises `busy_o` at the next clock edge. `busy_o` then stays high for max(WC_CYCLES, 64) cycles.
- R8: While `busy_o` is high, `start_i`, `byte_vld_i` and `commit_i` have no effect: `cur_addr_o` does not change and no new busy interval follows. `arr_we_o` is asserted only while `busy_o` is high.
- R9: `wel_clr_o` is high for exactly one cycle: the first cycle after `busy_o` falls.
- R10: Bytes and commits that arrive while no sequence is open (after reset or after a commit) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a write sequence at `start_addr_i` |
| start_addr_i | input | ADDR_W | First byte address of the sequence |
| byte_vld_i | input | 1 | One data byte is present on `byte_i` |
| byte_i | input | DATA_W | Data byte |
| commit_i | input | 1 | End of command (chip select released) |
| writable_i | input | 1 | `cur_addr_o` may be written |
| cur_addr_o | output | ADDR_W | Address the next byte will target |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Programming cycle in progress |
| wel_clr_o | output | 1 | Pulse to clear the write-enable latch |

## Verification
Some properties are checked on every cycle. Array writes only happen while busy. The page bits of the write address stay fixed across a busy interval. Every accepted byte steps the offset by exactly one modulo 64. An empty commit never raises busy. The write-enable clear pulse only follows a falling busy. Other behaviour needs the bench's scenarios: the final byte image at each offset after wraparound and overwrite, dropping bytes in a protected range, the exact busy length, and the effect of commands issued in the middle of programming. In those scenarios a model page built from the requirements is compared against the writes seen on the array port.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } seq_st_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ppb_offset_ctr.sv
module ppb_offset_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [BASE_W-1:0] base_q;
  logic [PAGE_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      base_q <= load_addr_i[ADDR_W-1:PAGE_W];
      off_q  <= load_addr_i[PAGE_W-1:0];
    end else if (step_i) begin
      off_q  <= off_q + 1'b1;  // low bits only: wraps inside page
    end
  end

  assign cur_addr_o = {base_q, off_q};

  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cur_addr_o[PAGE_W-1:0] == PAGE_W'($past(cur_addr_o[PAGE_W-1:0]) + 1'b1))); // R3
  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cur_addr_o[ADDR_W-1:PAGE_W])); // R2
endmodule

// File: rtl/ppb_store.sv
module ppb_store #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (clr_i)   vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !any_vld_o); // R4
endmodule

// File: rtl/ppb_seq.sv
module ppb_seq
  import ppb_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int WC_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic              commit_i,
  input  logic              any_vld_i,
  output logic              load_o,
  output logic              accept_o,
  output logic              clr_o,
  output logic              scan_act_o,
  output logic [PAGE_W-1:0] scan_idx_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BUSY_CYC   = max_i(WC_CYCLES, PAGE_BYTES);
  localparam int CNT_W      = $clog2(BUSY_CYC + 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             wel_q;
  logic             last, commit_ok;

  assign last      = (st_q == ST_PROG) && (cnt_q == CNT_W'(BUSY_CYC - 1));
  assign load_o    = start_i && (st_q != ST_PROG);
  assign accept_o  = byte_vld_i && (st_q == ST_FILL) && !start_i;
  assign commit_ok = commit_i && (st_q == ST_FILL) && !start_i;
  assign clr_o     = load_o || last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_FILL;
      ST_FILL: begin
        if (start_i)        st_d = ST_FILL;
        else if (commit_ok) st_d = any_vld_i ? ST_PROG : ST_IDLE;
      end
      ST_PROG: if (last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      wel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      wel_q <= last;
      if (st_q != ST_PROG) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o     = (st_q == ST_PROG);
  assign scan_act_o = busy_o && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_idx_o = cnt_q[PAGE_W-1:0];
  assign wel_clr_o  = wel_q;

  AST_EMPTY_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_ok && !any_vld_i) |=> !busy_o); // R6
  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_ok && any_vld_i) |=> busy_o); // R7
  AST_WEL_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> (!busy_o && $past(busy_o))); // R9
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_o && !accept_o); // R8
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int WC_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              writable_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  logic              load, accept, clr, scan_act, rd_vld, any_vld;
  logic [PAGE_W-1:0] scan_idx;
  logic [DATA_W-1:0] rd_data;

  ppb_seq #(.PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) u_seq (
    .clk_i, .rst_ni, .start_i, .byte_vld_i, .commit_i,
    .any_vld_i  (any_vld),
    .load_o     (load),
    .accept_o   (accept),
    .clr_o      (clr),
    .scan_act_o (scan_act),
    .scan_idx_o (scan_idx),
    .busy_o,
    .wel_clr_o
  );

  ppb_offset_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk_i, .rst_ni,
    .load_i      (load),
    .load_addr_i (start_addr_i),
    .step_i      (accept),
    .cur_addr_o
  );

  ppb_store #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .wr_en_i   (accept && writable_i),
    .wr_idx_i  (cur_addr_o[PAGE_W-1:0]),
    .wr_data_i (byte_i),
    .rd_idx_i  (scan_idx),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  assign arr_we_o    = scan_act && rd_vld;
  assign arr_addr_o  = {cur_addr_o[ADDR_W-1:PAGE_W], scan_idx};
  assign arr_wdata_o = rd_data;

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o); // R8
  AST_PAGE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(arr_addr_o[ADDR_W-1:PAGE_W])); // R2
endmodule

// File: tb/tb_page_prog_seq.sv
module tb_page_prog_seq;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int WC     = 100;
  localparam int BUSY   = (WC > 64) ? WC : 64;

  typedef struct packed {
    logic [12:0] addr;
    logic [7:0]  n;
    logic [7:0]  seed;
    logic [13:0] prot;  // first non-writable address
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{13'h0040, 8'd1,  8'h11, 14'h2000},
    '{13'h0085, 8'd10, 8'h20, 14'h2000},
    '{13'h00FA, 8'd10, 8'h35, 14'h2000},
    '{13'h0100, 8'd70, 8'h50, 14'h2000},
    '{13'h1FF0, 8'd20, 8'h66, 14'h1FF8},
    '{13'h1800, 8'd5,  8'h77, 14'h1000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, bvld = 1'b0, commit = 1'b0;
  logic [ADDR_W-1:0] saddr = '0;
  logic [DATA_W-1:0] bdat = '0;
  logic [13:0] prot = 14'h2000;
  logic writable;
  logic [ADDR_W-1:0] cur_addr, arr_addr;
  logic arr_we, busy, wel_clr;
  logic [DATA_W-1:0] arr_wdata;

  int n_chk = 0, n_fail = 0;
  logic       exp_v [64];
  logic [7:0] exp_d [64];
  logic       got_v [64];
  logic [7:0] got_d [64];
  int dups, badpg, nwr;

  always #4 clk = ~clk;
  assign writable = ({1'b0, cur_addr} < prot);

  page_prog_seq #(.ADDR_W(ADDR_W), .PAGE_W(6), .DATA_W(DATA_W), .WC_CYCLES(WC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .byte_vld_i(bvld), .byte_i(bdat), .commit_i(commit), .writable_i(writable),
    .cur_addr_o(cur_addr), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .busy_o(busy), .wel_clr_o(wel_clr)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic [12:0] a);
    @(negedge clk); start = 1'b1; saddr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); bvld = 1'b1; bdat = d;
    @(negedge clk); bvld = 1'b0;
  endtask

  // commit, then watch the busy interval; optionally inject commands mid-busy
  task automatic commit_watch(input logic [6:0] page, input bit inject, output int nb);
    for (int i = 0; i < 64; i++) begin got_v[i] = 1'b0; got_d[i] = '0; end
    dups = 0; badpg = 0; nwr = 0; nb = 0;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    while (busy && nb < 1000) begin
      if (arr_we) begin
        nwr++;
        if (got_v[arr_addr[5:0]]) dups++;
        got_v[arr_addr[5:0]] = 1'b1;
        got_d[arr_addr[5:0]] = arr_wdata;
        if (arr_addr[12:6] != page) badpg++;
      end
      if (inject && nb == 10) begin
        start = 1'b1; saddr = 13'h0AAA; bvld = 1'b1; bdat = 8'hEE; commit = 1'b1;
      end else begin
        start = 1'b0; bvld = 1'b0; commit = 1'b0;
      end
      nb++;
      @(negedge clk);
    end
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < 64; i++)
      if (got_v[i] != exp_v[i] || (exp_v[i] && got_d[i] != exp_d[i])) m++;
    return m;
  endfunction

  initial begin : wd
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL R7 watchdog: run not finished, expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int nb;
    bit any;
    logic [5:0] off;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(busy), 0, "busy in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(busy), 0, "busy after reset");
    chk("R1", int'(arr_we), 0, "arr_we after reset");
    chk("R1", int'(wel_clr), 0, "wel_clr after reset");
    chk("R1", int'(cur_addr), 0, "cur_addr after reset");

    // R10: bytes and commit before any start are ignored
    send(8'hAB); send(8'hCD);
    chk("R10", int'(cur_addr), 0, "offset moved with no open sequence");
    commit_watch(7'd0, 1'b0, nb);
    chk("R10", nb, 0, "busy cycles from commit with no sequence");

    // vector table: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      prot = VECS[v].prot;
      for (int i = 0; i < 64; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
      off = VECS[v].addr[5:0];
      any = 1'b0;
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        if ({1'b0, VECS[v].addr[12:6], off} < VECS[v].prot) begin
          exp_v[off] = 1'b1; exp_d[off] = 8'(VECS[v].seed + 8'(i * 7)); any = 1'b1;
        end
        off = off + 6'd1;
      end
      do_start(VECS[v].addr);
      for (int i = 0; i < int'(VECS[v].n); i++) send(8'(VECS[v].seed + 8'(i * 7)));
      chk("R3", int'(cur_addr), int'({VECS[v].addr[12:6], off}), $sformatf("vec %0d end address", v));
      commit_watch(VECS[v].addr[12:6], 1'b0, nb);
      if (any) begin
        chk("R7", nb, BUSY, $sformatf("vec %0d busy cycles", v));
        chk("R4", mism(), 0, $sformatf("vec %0d page image mismatches (R3/R5 wrap and drop)", v));
        chk("R4", dups, 0, $sformatf("vec %0d duplicate writes", v));
        chk("R2", badpg, 0, $sformatf("vec %0d writes outside page", v));
        chk("R9", int'(wel_clr), 1, $sformatf("vec %0d wel_clr first idle cycle", v));
        @(negedge clk);
        chk("R9", int'(wel_clr), 0, $sformatf("vec %0d wel_clr second idle cycle", v));
      end else begin
        chk("R6", nb, 0, $sformatf("vec %0d busy from empty commit", v));
        chk("R6", nwr, 0, $sformatf("vec %0d writes from empty commit", v));
        chk("R6", int'(wel_clr), 0, $sformatf("vec %0d wel_clr after empty commit", v));
      end
    end

    // R8: commands during busy are ignored
    prot = 14'h2000;
    for (int i = 0; i < 64; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
    do_start(13'h0123);
    send(8'h5A); send(8'hA5);
    exp_v[6'h23] = 1'b1; exp_d[6'h23] = 8'h5A;
    exp_v[6'h24] = 1'b1; exp_d[6'h24] = 8'hA5;
    commit_watch(7'h04, 1'b1, nb);
    chk("R8", nb, BUSY, "busy cycles with mid-busy commands");
    chk("R8", mism(), 0, "page image with mid-busy commands");
    chk("R8", int'(cur_addr), 13'h0125, "cur_addr after mid-busy start");
    repeat (3) @(negedge clk);
    chk("R8", int'(busy), 0, "busy restarted by mid-busy commit");

    // R10: bytes after a finished sequence are ignored
    send(8'h99);
    chk("R10", int'(cur_addr), 13'h0125, "offset moved after sequence closed");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule